// File: doc/BRIEF.md
# UART Special Character Detector

This block sits between a UART line receiver and its receive FIFO. It watches each received character and compares it with one programmed special character. Every character that arrives is forwarded to the FIFO write port one clock later, whether or not it matches. A match is never consumed the way a flow-control character would be. When detection is enabled and an error-free character matches, a sticky status flag is raised. The flag stays set until software clears it.

The comparison width follows the programmed word length. Only the low 5, 6, 7 or 8 bits take part, with bit 0 of the programmed value aligned to the character LSB. Characters that arrive with a framing or parity error are still forwarded, but they never raise the flag.

Top module: `spchar_detect`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `fifo_wr` and `sp_flag` are 0.
- R2: Every cycle with `rx_valid`=1 produces `fifo_wr`=1 on the next cycle, with `fifo_data` equal to that `rx_data`. This holds regardless of the enable, the match result or the error flag, so no character is consumed.
- R3: A cycle with `rx_valid`=0 produces `fifo_wr`=0 on the next cycle.
- R4: With `det_en`=1, `rx_valid`=1, `rx_err`=0 and a match on the compared bits, `sp_flag` is 1 on the next cycle.
- R5: The compared bits are the low 5+`wlen` bits: `wlen`=0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Bit i of `match_chr` is compared with bit i of `rx_data`, and bits above the width are ignored.
- R6: With `det_en`=0, no character sets `sp_flag`.
- R7: A character with `rx_err`=1 does not set `sp_flag`, but it is still forwarded.
- R8: Once set, `sp_flag` holds until `flag_clr`=1 is seen at a clock edge with no match. It reads 0 on the next cycle.
- R9: A match in the same cycle as `flag_clr`=1 leaves `sp_flag` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Enables special character detection |
| wlen | input | 2 | Word length code, giving 5+wlen compared bits |
| match_chr | input | 8 | Programmed special character |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | `rx_data` is a new character this cycle |
| rx_err | input | 1 | The character has a framing or parity error |
| flag_clr | input | 1 | Clears the sticky flag |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character written to the FIFO |
| sp_flag | output | 1 | Sticky special-character status |

## Verification
Two things can fall in the same cycle: a fresh match that sets the flag, and a software clear that drops it. The bench first sets the flag. It then drives `flag_clr` together with a matching character and expects the flag still set on the next cycle, while the FIFO write still appears. It repeats the clear with a non-matching character and expects the flag to drop while that character is forwarded.

// File: rtl/spchar_pkg.sv
// Shared constants and the word-length encoding for the special character detector.
// Assumes characters are at most 8 bits and never shorter than 5.
package spchar_pkg;
    localparam int CHAR_W   = 8;
    localparam int WLEN_W   = 2;
    localparam int MIN_BITS = 5;

    typedef enum logic [WLEN_W-1:0] {
        WL_5 = 2'd0,
        WL_6 = 2'd1,
        WL_7 = 2'd2,
        WL_8 = 2'd3
    } wlen_e;
endpackage

// File: rtl/spchar_mask.sv
// Builds the compare mask from the word-length code: the low MIN_BITS+wlen bits are set.
// Assumes MIN_BITS + 2**WLEN_W - 1 >= CHAR_W, so code all-ones covers the full character.
module spchar_mask #(
    parameter int CHAR_W   = spchar_pkg::CHAR_W,
    parameter int WLEN_W   = spchar_pkg::WLEN_W,
    parameter int MIN_BITS = spchar_pkg::MIN_BITS
) (
    input  logic [WLEN_W-1:0] wlen,
    output logic [CHAR_W-1:0] mask
);
    // One decode term per bit: always on below MIN_BITS, otherwise enabled by the code.
    for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
        if (i < MIN_BITS) begin : g_fixed
            assign mask[i] = 1'b1;
        end else begin : g_coded
            assign mask[i] = (int'(wlen) >= (i - MIN_BITS + 1));
        end
    end
endmodule

// File: rtl/spchar_cmp.sv
// Decides whether the character in this cycle is a qualified special-character hit.
// Assumes rx_err marks framing or parity trouble for the same character as rx_data.
module spchar_cmp #(
    parameter int CHAR_W = spchar_pkg::CHAR_W
) (
    input  logic              det_en,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic [CHAR_W-1:0] match_chr,
    input  logic [CHAR_W-1:0] mask,
    output logic              hit
);
    logic same;

    // Masked equality, qualified by enable, strobe and a clean character.
    always_comb begin
        same = (((rx_data ^ match_chr) & mask) == '0);
        hit  = det_en && rx_valid && !rx_err && same;
    end
endmodule

// File: rtl/spchar_pass.sv
// Forwards every received character to the FIFO write port with one register stage.
// Assumes the FIFO accepts a write on every cycle in which fifo_wr is high.
module spchar_pass #(
    parameter int CHAR_W = spchar_pkg::CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_data
);
    // Register the strobe and the character; nothing is ever withheld.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_wr   <= rx_valid;
            fifo_data <= rx_valid ? rx_data : fifo_data;
        end
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fifo_wr && fifo_data == $past(rx_data))); // R2
    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !fifo_wr); // R3
endmodule

// File: rtl/spchar_sticky.sv
// Holds the special-character status flag: set by a hit, cleared by a strobe, set wins.
// Assumes hit and clr are synchronous to clk.
module spchar_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    // Set has priority over clear so a match is never lost to a concurrent clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R8
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag); // R8
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R9
endmodule

// File: rtl/spchar_detect.sv
// Top of the special character detector: forwards all received characters to the FIFO
// and raises a sticky flag when an enabled, error-free character matches the programmed
// value over the word-length-selected bits.
// Assumes software flow control is off while this mode is used; no character is consumed.
module spchar_detect #(
    parameter int CHAR_W   = spchar_pkg::CHAR_W,
    parameter int WLEN_W   = spchar_pkg::WLEN_W,
    parameter int MIN_BITS = spchar_pkg::MIN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_en,
    input  logic [WLEN_W-1:0] wlen,
    input  logic [CHAR_W-1:0] match_chr,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_err,
    input  logic              flag_clr,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              sp_flag
);
    logic [CHAR_W-1:0] mask;
    logic              hit;

    spchar_mask #(.CHAR_W(CHAR_W), .WLEN_W(WLEN_W), .MIN_BITS(MIN_BITS)) u_mask (
        .wlen (wlen),
        .mask (mask)
    );

    spchar_cmp #(.CHAR_W(CHAR_W)) u_cmp (
        .det_en    (det_en),
        .rx_valid  (rx_valid),
        .rx_err    (rx_err),
        .rx_data   (rx_data),
        .match_chr (match_chr),
        .mask      (mask),
        .hit       (hit)
    );

    spchar_pass #(.CHAR_W(CHAR_W)) u_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );

    spchar_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (sp_flag)
    );

    AST_FULL_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && rx_valid && !rx_err && rx_data == match_chr) |=> sp_flag); // R4
    AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_flag && !det_en) |=> !sp_flag); // R6
    AST_ERROR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_flag && (rx_err || !rx_valid)) |=> !sp_flag); // R7
endmodule

// File: tb/sim_spchar_detect.sv
module sim_spchar_detect;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       det_en;
    logic [1:0] wlen;
    logic [7:0] match_chr;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_err;
    logic       flag_clr;
    logic       fifo_wr;
    logic [7:0] fifo_data;
    logic       sp_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    spchar_detect u0 (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .wlen(wlen),
        .match_chr(match_chr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_err(rx_err), .flag_clr(flag_clr), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .sp_flag(sp_flag)
    );

    // Vector fields: {en, wlen[1:0], err, match_chr[7:0], rx_data[7:0], expected flag}
    localparam int NVEC = 12;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 2'd3, 1'b0, 8'h13, 8'h13, 1'b1},  // R4 full 8-bit match
        {1'b1, 2'd3, 1'b0, 8'h13, 8'h93, 1'b0},  // R5 bit7 compared at 8 bits
        {1'b1, 2'd2, 1'b0, 8'h13, 8'h93, 1'b1},  // R5 bit7 ignored at 7 bits
        {1'b1, 2'd2, 1'b0, 8'h13, 8'h53, 1'b0},  // R5 bit6 compared at 7 bits
        {1'b1, 2'd1, 1'b0, 8'h13, 8'h53, 1'b1},  // R5 bit6 ignored at 6 bits
        {1'b1, 2'd1, 1'b0, 8'h13, 8'h33, 1'b0},  // R5 bit5 compared at 6 bits
        {1'b1, 2'd0, 1'b0, 8'h13, 8'h33, 1'b1},  // R5 bit5 ignored at 5 bits
        {1'b1, 2'd0, 1'b0, 8'h13, 8'h1B, 1'b0},  // R5 bit3 always compared
        {1'b0, 2'd3, 1'b0, 8'h13, 8'h13, 1'b0},  // R6 disabled
        {1'b1, 2'd3, 1'b1, 8'h13, 8'h13, 1'b0},  // R7 error character
        {1'b1, 2'd0, 1'b0, 8'hE5, 8'h05, 1'b1},  // R5 upper register bits ignored
        {1'b1, 2'd3, 1'b0, 8'h00, 8'h00, 1'b1}   // R4 all-zero character
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one character for one cycle; on return, outputs of that cycle are visible.
    task automatic send(input logic [7:0] d, input logic err, input logic clr);
        @(negedge clk);
        rx_data  = d;
        rx_err   = err;
        rx_valid = 1'b1;
        flag_clr = clr;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_err   = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        int limit;
        limit = 5000;
        while (limit > 0 && !done) begin
            @(posedge clk);
            limit--;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; det_en = 1'b0; wlen = 2'd3; match_chr = 8'h00;
        rx_data = 8'h00; rx_valid = 1'b0; rx_err = 1'b0; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(fifo_wr == 1'b0, "R1 fifo_wr in reset", fifo_wr, 0);
        check(sp_flag == 1'b0, "R1 sp_flag in reset", sp_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int k = 0; k < NVEC; k++) begin
            det_en    = VEC[k][20];
            wlen      = VEC[k][19:18];
            match_chr = VEC[k][16:9];
            send(VEC[k][8:1], VEC[k][17], 1'b0);
            check(fifo_wr == 1'b1, $sformatf("R2 vec%0d fifo_wr", k), fifo_wr, 1);
            check(fifo_data == VEC[k][8:1], $sformatf("R2 vec%0d fifo_data", k),
                  fifo_data, VEC[k][8:1]);
            check(sp_flag == VEC[k][0], $sformatf("R4/R5 vec%0d sp_flag", k),
                  sp_flag, VEC[k][0]);
            clear_flag();
            check(sp_flag == 1'b0, $sformatf("R8 vec%0d cleared", k), sp_flag, 0);
        end

        // R3: idle cycles write nothing
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(fifo_wr == 1'b0, "R3 idle no write", fifo_wr, 0);
        end

        // R8: flag holds across idle cycles and non-matching characters
        det_en = 1'b1; wlen = 2'd3; match_chr = 8'hA5;
        send(8'hA5, 1'b0, 1'b0);
        check(sp_flag == 1'b1, "R4 set before hold", sp_flag, 1);
        repeat (4) @(negedge clk);
        check(sp_flag == 1'b1, "R8 holds while idle", sp_flag, 1);
        send(8'h5A, 1'b0, 1'b0);
        check(sp_flag == 1'b1, "R8 holds over mismatch", sp_flag, 1);

        // R9: clear together with a match keeps the flag
        send(8'hA5, 1'b0, 1'b1);
        check(sp_flag == 1'b1, "R9 match beats clear", sp_flag, 1);
        check(fifo_wr == 1'b1 && fifo_data == 8'hA5, "R9 match still forwarded",
              fifo_data, 8'hA5);

        // R8: clear together with a non-matching character drops the flag
        send(8'h3C, 1'b0, 1'b1);
        check(sp_flag == 1'b0, "R8 clear with mismatch", sp_flag, 0);
        check(fifo_data == 8'h3C, "R2 char during clear forwarded", fifo_data, 8'h3C);

        // R7: error character forwarded during a set flag-free state
        send(8'hA5, 1'b1, 1'b0);
        check(sp_flag == 1'b0, "R7 error match ignored", sp_flag, 0);
        check(fifo_wr == 1'b1 && fifo_data == 8'hA5, "R7 error char forwarded",
              fifo_data, 8'hA5);

        // R2: back-to-back characters each forwarded in order
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h11;
        @(negedge clk);
        check(fifo_wr == 1'b1 && fifo_data == 8'h11, "R2 back-to-back first",
              fifo_data, 8'h11);
        rx_data = 8'h22;
        @(negedge clk);
        rx_valid = 1'b0;
        check(fifo_wr == 1'b1 && fifo_data == 8'h22, "R2 back-to-back second",
              fifo_data, 8'h22);
        @(negedge clk);
        check(fifo_wr == 1'b0, "R3 write drops after burst", fifo_wr, 0);

        // R1: reset clears a set flag
        send(8'hA5, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check(sp_flag == 1'b0, "R1 reset clears flag", sp_flag, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule